// File: doc/BRIEF.md
# Four-Channel LED Intensity and Blink Controller

This block drives four LED sink-enable outputs. Each channel has a 256-step pulse-width intensity and an optional slow on/off blink pattern, and the blink pattern gates the intensity output. A host programs eight-bit registers through a simple write port. Each channel has its own intensity byte and a configuration byte, and all channels share one common intensity byte. In its configuration byte, each channel chooses whether it follows the common byte or its own.

An external step enable, `pwm_step`, advances one intensity counter that all channels share, so every channel's PWM period starts on the same step. A separate one-millisecond tick advances a free-running blink counter. A new intensity value, or a change of intensity source, is held back until the shared counter wraps. Because of this, no period ever mixes two settings.

Top module: `led_pwm_blink`

## Requirements
- R1: With an active intensity N from 0x00 to 0xFE, an output sinks during exactly N of each 256 steps, namely while the shared step count is below N.
- R2: An active intensity of 0xFF makes the output sink on every step, provided its blink gate is open.
- R3: Bit 0 of a channel's configuration byte selects the intensity source: 0 selects the channel's own byte and 1 selects the common byte.
- R4: One write to the common byte changes the intensity of every channel that selects it and leaves the other channels unchanged.
- R5: A new intensity value or source takes effect only on the step that wraps the shared count from 255 to 0. A write in mid-period leaves the current period unchanged.
- R6: Configuration bits [3:1] form the blink period field F. F = 0 disables blinking. For F from 1 to 7, the blink period is 64·2^(F−1) ticks, which ranges from 64 to 4096 ticks.
- R7: Configuration bits [5:4] set the blink on-share at the start of each period: 00 gives 1/2, 01 gives 1/4, 10 gives 1/8 and 11 gives 3/4. During the rest of the period the output is forced off.
- R8: Write address map: addresses 0–3 hold the own intensity of channels 0–3, addresses 4–7 hold the configuration of channels 0–3, and address 8 holds the common intensity. Writes to addresses 9–15 change nothing.
- R9: Reset clears all registers, the step count and the tick count, and all outputs are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| pwm_step | input | 1 | Advances the shared intensity counter by one step |
| ms_tick | input | 1 | One-millisecond tick that advances the blink counter |
| led_sink | output | 4 | Sink enable for each channel |

## Verification
The assertions assume that `pwm_step` and `ms_tick` are plain clock-synchronous levels: every clock with `pwm_step` high counts as one step, even across many consecutive cycles. The assertions also rely on the active intensity register changing only on the wrap step. The stimulus changes inputs only on falling clock edges. It holds `pwm_step` high for whole 256-step periods that start at count 0, and writes in mid-period only inside those measured periods, to test the deferred load. During the blink runs `pwm_step` is held low, so that blink gating is seen apart from the intensity.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;
  localparam int DUTY_W          = 8;
  localparam int BPER_W          = 3;
  localparam int BDUTY_W         = 2;
  localparam int BLINK_BASE_LOG2 = 6;
  localparam int MS_W            = BLINK_BASE_LOG2 + (1 << BPER_W) - 2;
  localparam int RSVD_W          = DUTY_W - 1 - BPER_W - BDUTY_W;

  typedef logic [DUTY_W-1:0] duty_t;

  typedef struct packed {
    logic [RSVD_W-1:0]  rsvd;
    logic [BDUTY_W-1:0] bduty;
    logic [BPER_W-1:0]  bper;
    logic               use_common;
  } chan_cfg_t;

  // Intensity comparison: full code means continuously on.
  function automatic logic pwm_level(input duty_t duty, input duty_t cnt);
    return (duty == '1) || (cnt < duty);
  endfunction

  // Blink period in ticks for a nonzero period field.
  function automatic logic [MS_W:0] blink_period(input logic [BPER_W-1:0] per);
    return (MS_W+1)'(1) << (BLINK_BASE_LOG2 + int'(per) - 1);
  endfunction

  // Number of ticks the LED stays on at the start of each blink period.
  function automatic logic [MS_W:0] blink_threshold(input logic [BPER_W-1:0] per,
                                                    input logic [BDUTY_W-1:0] code);
    logic [MS_W:0] p;
    p = blink_period(per);
    case (code)
      2'd0:    return p >> 1;
      2'd1:    return p >> 2;
      2'd2:    return p >> 3;
      default: return (p >> 1) + (p >> 2);
    endcase
  endfunction

  function automatic logic blink_level(input logic [BPER_W-1:0] per,
                                       input logic [BDUTY_W-1:0] code,
                                       input logic [MS_W-1:0] ms);
    logic [MS_W:0] phase;
    if (per == '0) return 1'b1;
    phase = {1'b0, ms} & (blink_period(per) - (MS_W+1)'(1));
    return phase < blink_threshold(per, code);
  endfunction
endpackage

// File: rtl/led_regs.sv
module led_regs
  import led_pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  duty_t                    wr_data,
  output duty_t     [NUM_CH-1:0]   own_duty,
  output chan_cfg_t [NUM_CH-1:0]   cfg,
  output duty_t                    common_duty
);
  localparam int CFG_BASE = NUM_CH;
  localparam int COM_ADDR = 2 * NUM_CH;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit_own, hit_cfg;
    assign hit_own = wr_en && (wr_addr == ADDR_W'(i));
    assign hit_cfg = wr_en && (wr_addr == ADDR_W'(CFG_BASE + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_duty[i] <= '0;
        cfg[i]      <= '0;
      end else begin
        if (hit_own) own_duty[i] <= wr_data;
        if (hit_cfg) cfg[i]      <= chan_cfg_t'(wr_data);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      common_duty <= '0;
    else if (wr_en && wr_addr == ADDR_W'(COM_ADDR)) common_duty <= wr_data;
  end
endmodule

// File: rtl/led_pwm_chan.sv
module led_pwm_chan
  import led_pwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cycle_load,
  input  logic  use_common,
  input  duty_t own_duty,
  input  duty_t common_duty,
  input  duty_t step_cnt,
  output duty_t act_duty,
  output logic  pwm_on
);
  duty_t next_duty;
  assign next_duty = use_common ? common_duty : own_duty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          act_duty <= '0;
    else if (cycle_load) act_duty <= next_duty;
  end

  assign pwm_on = pwm_level(act_duty, step_cnt);
endmodule

// File: rtl/led_blink_chan.sv
module led_blink_chan
  import led_pwm_pkg::*;
(
  input  logic [BPER_W-1:0]  bper,
  input  logic [BDUTY_W-1:0] bduty,
  input  logic [MS_W-1:0]    ms_cnt,
  output logic               blink_on
);
  assign blink_on = blink_level(bper, bduty, ms_cnt);
endmodule

// File: rtl/led_pwm_blink.sv
module led_pwm_blink
  import led_pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              pwm_step,
  input  logic              ms_tick,
  output logic [NUM_CH-1:0] led_sink
);
  duty_t     [NUM_CH-1:0] own_duty;
  chan_cfg_t [NUM_CH-1:0] cfg;
  duty_t                  common_duty;
  duty_t                  step_cnt;
  logic      [MS_W-1:0]   ms_cnt;
  logic                   cycle_load;
  duty_t     [NUM_CH-1:0] act_duty;
  logic      [NUM_CH-1:0] pwm_on;
  logic      [NUM_CH-1:0] blink_on;

  led_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(duty_t'(wr_data)), .own_duty(own_duty), .cfg(cfg),
    .common_duty(common_duty)
  );

  // The shared step counter aligns the PWM period of every channel.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        step_cnt <= '0;
    else if (pwm_step) step_cnt <= step_cnt + duty_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ms_cnt <= '0;
    else if (ms_tick) ms_cnt <= ms_cnt + MS_W'(1);
  end

  // This step wraps the count to zero; it is the only load point.
  assign cycle_load = pwm_step && (step_cnt == '1);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    led_pwm_chan u_pwm (
      .clk(clk), .rst_n(rst_n), .cycle_load(cycle_load),
      .use_common(cfg[i].use_common), .own_duty(own_duty[i]),
      .common_duty(common_duty), .step_cnt(step_cnt),
      .act_duty(act_duty[i]), .pwm_on(pwm_on[i])
    );
    led_blink_chan u_blink (
      .bper(cfg[i].bper), .bduty(cfg[i].bduty), .ms_cnt(ms_cnt),
      .blink_on(blink_on[i])
    );
    assign led_sink[i] = pwm_on[i] & blink_on[i];
  end
endmodule

// File: rtl/led_pwm_blink_chk.sv
module led_pwm_blink_chk
  import led_pwm_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   pwm_step,
  input duty_t                  step_cnt,
  input logic                   cycle_load,
  input duty_t   [NUM_CH-1:0]   act_duty,
  input logic    [NUM_CH-1:0]   blink_on,
  input logic    [NUM_CH-1:0]   led_sink
);
  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_step |=> step_cnt == $past(step_cnt) + duty_t'(1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_step |=> $stable(step_cnt)); // R5
  AST_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_load |=> step_cnt == '0); // R5
  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_load |=> $stable(act_duty)); // R5

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (act_duty[i] == '1 && blink_on[i]) |-> led_sink[i]); // R2
    AST_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (act_duty[i] == '0) |-> !led_sink[i]); // R1
    AST_BLINK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !blink_on[i] |-> !led_sink[i]); // R7
  end
endmodule

bind led_pwm_blink led_pwm_blink_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_step(pwm_step), .step_cnt(step_cnt),
  .cycle_load(cycle_load), .act_duty(act_duty), .blink_on(blink_on),
  .led_sink(led_sink)
);

// File: tb/tb_led_pwm_blink.sv
module tb_led_pwm_blink;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_step = 1'b0;
  logic       ms_tick = 1'b0;
  logic [3:0] led_sink;

  int errors = 0;
  int checks = 0;
  int pwm_phase = 0;
  int ms_phase = 0;
  int meas[4];
  bit done = 1'b0;

  always #4 clk = ~clk;

  led_pwm_blink dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_step(pwm_step), .ms_tick(ms_tick),
    .led_sink(led_sink)
  );

  // {config, own duty, common duty, expected on-steps of 256}
  localparam logic [39:0] VEC [8] = '{
    {8'h00, 8'h00, 8'h55, 16'd0},    // R1 zero
    {8'h00, 8'h01, 8'h55, 16'd1},    // R1 one
    {8'h00, 8'h80, 8'h55, 16'd128},  // R1 half
    {8'h00, 8'hFE, 8'h55, 16'd254},  // R1 top below full
    {8'h00, 8'hFF, 8'h55, 16'd256},  // R2 full
    {8'h01, 8'h10, 8'h33, 16'd51},   // R3 common
    {8'h01, 8'h33, 8'hFF, 16'd256},  // R3 common full
    {8'h01, 8'hFF, 8'h00, 16'd0}     // R3 common zero
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; pwm_step = 1'b0; ms_tick = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pwm_step = 1'b1;
      pwm_phase = (pwm_phase + 1) % 256;
    end
    @(negedge clk);
    pwm_step = 1'b0;
  endtask

  // Reach count 0, then run one full period so pending values become active.
  task automatic apply();
    steps((256 - pwm_phase) % 256);
    steps(256);
  endtask

  // One period from count 0, optionally writing at step index 'at'.
  task automatic measure_w(input int at, input logic [3:0] a, input logic [7:0] d);
    for (int c = 0; c < 4; c++) meas[c] = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) meas[c] += int'(led_sink[c]);
      pwm_step = 1'b1;
      wr_en = (i == at); wr_addr = a; wr_data = d;
    end
    @(negedge clk);
    pwm_step = 1'b0; wr_en = 1'b0;
  endtask

  task automatic blink_run(input int ch, output int on_cnt, output int falls);
    logic prev;
    logic cur;
    prev = 1'b0;
    on_cnt = 0; falls = 0;
    for (int i = 0; i < (4096 - ms_phase) % 4096; i++) begin
      @(negedge clk); ms_tick = 1'b1;
    end
    ms_phase = 0;
    for (int i = 0; i < 4096; i++) begin
      @(negedge clk);
      cur = led_sink[ch];
      on_cnt += int'(cur);
      if (i > 0 && prev && !cur) falls++;
      prev = cur;
      ms_tick = 1'b1; pwm_step = 1'b0;
    end
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int on_cnt, falls;
    int per, bd, cfgv, exp_on, exp_falls;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset outputs off", int'(led_sink), 0);
    measure_w(-1, 4'd0, 8'd0);
    check("R9 reset duty zero ch0", meas[0], 0);
    check("R9 reset duty zero ch3", meas[3], 0);

    // Table of intensity vectors on channel 0
    for (int v = 0; v < 8; v++) begin
      wr(4'd0, VEC[v][31:24]);
      wr(4'd4, VEC[v][39:32]);
      wr(4'd8, VEC[v][23:16]);
      apply();
      measure_w(-1, 4'd0, 8'd0);
      check($sformatf("R1/R2/R3 vector %0d", v), meas[0], int'(VEC[v][15:0]));
    end

    // R4: common write fans out only to selecting channels
    wr(4'd4, 8'h00); wr(4'd0, 8'h10);
    wr(4'd5, 8'h01); wr(4'd6, 8'h01);
    wr(4'd7, 8'h00); wr(4'd3, 8'hF0);
    wr(4'd8, 8'h70);
    apply(); measure_w(-1, 4'd0, 8'd0);
    check("R4 own ch0", meas[0], 16);
    check("R4 common ch1", meas[1], 112);
    check("R4 common ch2", meas[2], 112);
    check("R4 own ch3", meas[3], 240);
    wr(4'd8, 8'h08);
    apply(); measure_w(-1, 4'd0, 8'd0);
    check("R4 new common ch1", meas[1], 8);
    check("R4 new common ch2", meas[2], 8);
    check("R4 ch0 unchanged", meas[0], 16);
    check("R4 ch3 unchanged", meas[3], 240);

    // R8: unmapped addresses are ignored
    wr(4'd12, 8'h01); wr(4'd9, 8'hFF); wr(4'd15, 8'hFF);
    apply(); measure_w(-1, 4'd0, 8'd0);
    check("R8 ch0 after unmapped writes", meas[0], 16);
    check("R8 ch1 after unmapped writes", meas[1], 8);
    check("R8 ch3 after unmapped writes", meas[3], 240);

    // R5: mid-period value change is deferred
    wr(4'd0, 8'h40); apply();
    measure_w(10, 4'd0, 8'h80);
    check("R5 old value holds this period", meas[0], 64);
    measure_w(-1, 4'd0, 8'd0);
    check("R5 new value next period", meas[0], 128);
    // R5: mid-period source switch is deferred
    wr(4'd0, 8'h20); wr(4'd8, 8'hC0); apply();
    measure_w(5, 4'd4, 8'h01);
    check("R5 source switch deferred", meas[0], 32);
    measure_w(-1, 4'd0, 8'd0);
    check("R5 common source next period", meas[0], 192);

    // R6/R7: blink on channel 1 with full intensity
    wr(4'd5, 8'h00); wr(4'd1, 8'hFF); apply();
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: begin per = 1; bd = 0; end
        1: begin per = 3; bd = 1; end
        2: begin per = 7; bd = 2; end
        3: begin per = 2; bd = 3; end
        4: begin per = 0; bd = 1; end
        default: begin per = 7; bd = 3; end
      endcase
      cfgv = (bd << 4) | (per << 1);
      wr(4'd5, 8'(cfgv));
      blink_run(1, on_cnt, falls);
      if (per == 0) begin
        exp_on = 4096; exp_falls = 0;
      end else begin
        exp_on = (bd == 0) ? 2048 : (bd == 1) ? 1024 : (bd == 2) ? 512 : 3072;
        exp_falls = 4096 / (64 << (per - 1));
      end
      check($sformatf("R7 on-ticks per=%0d code=%0d", per, bd), on_cnt, exp_on);
      check($sformatf("R6 periods per=%0d code=%0d", per, bd), falls, exp_falls);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule